// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a direct-mapped cache and keeps a short FIFO of blocks fetched ahead of the processor. When the cache misses, it presents the missed block address on the lookup port. The prefetcher compares that address with the oldest entry of its FIFO only. On a match the entry's block is returned in the same cycle, the entry is popped, and one more sequential block is requested to refill the tail. On a mismatch the FIFO is emptied and a new stream is started at the missed address plus one. The cache itself fetches the missed block; the prefetcher fetches only the blocks that follow it.

Prefetch requests go to the next memory level over a valid/ready request port. Responses come back in request order on a valid-only port. Entries are allocated when the request is issued and become valid when the response arrives. A request issued before a restart or a flush has its response counted and dropped. The total number of unanswered requests, dropped ones included, is capped at the FIFO depth. A flush input empties the buffer and holds it idle until the next miss.

The controller has three states. `SB_IDLE` means no stream. `SB_FILL` means the stream has free slots and may issue requests. `SB_FULL` means every slot is allocated. These transitions apply:
- flush, from any state, leads to `SB_IDLE`.
- A lookup miss, from any state, leads to `SB_FILL` (restart).
- In `SB_FILL` or `SB_FULL`, the next state is `SB_FULL` when the allocated count reaches the depth, and `SB_FILL` otherwise.
- `SB_IDLE` is held when there is neither flush nor lookup.

Top module: `stream_prefetch`

## Requirements
- R1: Out of reset the buffer is empty: `pf_req_valid` is 0 and a lookup cannot hit.
- R2: A lookup miss starts a stream whose first request, made in the cycle after the miss, is for the missed address plus one.
- R3: Each later request of a stream is for the address of the previous request plus one.
- R4: At most DEPTH entries are allocated. With no lookups, a new stream issues exactly DEPTH requests and then stops.
- R5: `lk_hit` is 1 in the same cycle as `lk_valid` when the head entry is valid and its tag equals `lk_addr`. `lk_data` then carries that entry's block.
- R6: A hit pops the head entry, so the next entry becomes the head. The freed slot leads to one more request, at the next sequential address.
- R7: A head entry whose response has not yet arrived does not match. A lookup at its address is treated as a miss and restarts the stream.
- R8: A lookup that does not match the head empties the buffer and restarts the stream at its address plus one.
- R9: Only the head entry is compared. A lookup at the address of a later entry is a miss.
- R10: A flush empties the buffer. From the next cycle until the next lookup miss, no request is made and no lookup hits.
- R11: Responses to requests issued before a flush or restart are discarded and never fill a later entry.
- R12: Issued but unanswered requests, discarded ones included, never exceed DEPTH.
- R13: Responses fill entries in the order the requests were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and stop the stream |
| lk_valid | input | 1 | Cache miss lookup present |
| lk_addr | input | ADDR_W | Missed block address |
| lk_hit | output | 1 | Head entry matched the lookup |
| lk_data | output | BLK_W | Block data of the head entry |
| pf_req_valid | output | 1 | Prefetch request valid |
| pf_req_ready | input | 1 | Next level accepts the request |
| pf_req_addr | output | ADDR_W | Block address to prefetch |
| pf_rsp_valid | input | 1 | In-order prefetch response valid |
| pf_rsp_data | input | BLK_W | Block returned by the next level |

## Verification
The bench builds the block with DEPTH 4, 16-bit block addresses and 32-bit blocks. Each block's data is formed from its own address, so any fill of the wrong entry, or a response that should have been dropped, shows up as a data mismatch on a hit. A depth of 4 makes the cap on unanswered requests reachable within a few cycles. The bench holds back responses while it restarts and flushes the stream, so it can observe the discard path and the cap together.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_IDLE = 2'd0,
        SB_FILL = 2'd1,
        SB_FULL = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_store.sv
// Tagged FIFO of prefetched blocks; DEPTH must be a power of two.
module sb_store #(
    parameter int ADDR_W = 26,
    parameter int BLK_W  = 256,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_tag,
    input  logic              fill_en,
    input  logic [BLK_W-1:0]  fill_data,
    input  logic              pop_en,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_tag,
    output logic [BLK_W-1:0]  head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]     head_ptr, tail_ptr, fill_ptr;
    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [BLK_W-1:0]  dat_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            fill_ptr <= '0;
            vld_q    <= '0;
        end else if (clr) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            fill_ptr <= '0;
            vld_q    <= '0;
        end else begin
            if (alloc_en) tail_ptr <= tail_ptr + PW'(1);
            if (fill_en)  fill_ptr <= fill_ptr + PW'(1);
            if (pop_en)   head_ptr <= head_ptr + PW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                if (fill_en && fill_ptr == PW'(i))
                    vld_q[i] <= 1'b1;
                else if (pop_en && head_ptr == PW'(i))
                    vld_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && tail_ptr == PW'(i)) tag_q[i] <= alloc_tag;
            if (fill_en && fill_ptr == PW'(i))  dat_q[i] <= fill_data;
        end
    end

    assign head_valid = vld_q[head_ptr];
    assign head_tag   = tag_q[head_ptr];
    assign head_data  = dat_q[head_ptr];
endmodule

// File: rtl/sb_track.sv
// Counts responses still owed for requests whose entries were thrown away.
module sb_track #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          req_fire,
    input  logic          rsp_fire,
    input  logic [CW-1:0] pend,
    output logic [CW-1:0] drop_cnt,
    output logic          rsp_keep
);
    logic [CW:0] owed;

    always_comb begin
        owed = {1'b0, drop_cnt} + {1'b0, pend} + (CW+1)'(req_fire);
        if (rsp_fire && owed != '0) owed = owed - (CW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drop_cnt <= '0;
        else if (clr)
            drop_cnt <= owed[CW-1:0];
        else if (rsp_fire && drop_cnt != '0)
            drop_cnt <= drop_cnt - CW'(1);
    end

    assign rsp_keep = rsp_fire && (drop_cnt == '0);
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
    import sb_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int BLK_W  = 256,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [BLK_W-1:0]  lk_data,
    output logic              pf_req_valid,
    input  logic              pf_req_ready,
    output logic [ADDR_W-1:0] pf_req_addr,
    input  logic              pf_rsp_valid,
    input  logic [BLK_W-1:0]  pf_rsp_data
);
    localparam int CW = $clog2(DEPTH + 1);

    sb_state_e         state_q, state_d;
    logic [ADDR_W-1:0] next_addr_q;
    logic [CW-1:0]     cnt_q, cnt_d, pend_q, pend_d, drop_cnt;
    logic              head_valid, rsp_keep;
    logic [ADDR_W-1:0] head_tag;
    logic [BLK_W-1:0]  head_data;
    logic              restart, clr, req_fire, alloc_en, fill_en, pop_en;

    // Outputs
    always_comb begin
        lk_hit       = lk_valid && head_valid && (head_tag == lk_addr);
        lk_data      = head_data;
        pf_req_valid = (state_q == SB_FILL) &&
                       (({1'b0, drop_cnt} + {1'b0, pend_q}) < (CW+1)'(DEPTH));
        pf_req_addr  = next_addr_q;
    end

    assign restart  = lk_valid && !lk_hit;
    assign clr      = flush || restart;
    assign req_fire = pf_req_valid && pf_req_ready;
    assign alloc_en = req_fire && !clr;
    assign fill_en  = rsp_keep && (pend_q != '0) && !clr;
    assign pop_en   = lk_hit && !flush;

    always_comb begin
        cnt_d  = clr ? '0 : cnt_q + CW'(alloc_en) - CW'(pop_en);
        pend_d = clr ? '0 : pend_q + CW'(alloc_en) - CW'(fill_en);
        unique case (state_q)
            SB_IDLE:          state_d = SB_IDLE;
            SB_FILL, SB_FULL: state_d = (cnt_d == CW'(DEPTH)) ? SB_FULL : SB_FILL;
            default:          state_d = SB_IDLE;
        endcase
        if (restart) state_d = SB_FILL;
        if (flush)   state_d = SB_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SB_IDLE;
            next_addr_q <= '0;
            cnt_q       <= '0;
            pend_q      <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            if (flush)
                next_addr_q <= next_addr_q;
            else if (restart)
                next_addr_q <= lk_addr + ADDR_W'(1);
            else if (alloc_en)
                next_addr_q <= next_addr_q + ADDR_W'(1);
        end
    end

    sb_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .alloc_en   (alloc_en),
        .alloc_tag  (next_addr_q),
        .fill_en    (fill_en),
        .fill_data  (pf_rsp_data),
        .pop_en     (pop_en),
        .head_valid (head_valid),
        .head_tag   (head_tag),
        .head_data  (head_data)
    );

    sb_track #(.DEPTH(DEPTH)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .req_fire (req_fire),
        .rsp_fire (pf_rsp_valid),
        .pend     (pend_q),
        .drop_cnt (drop_cnt),
        .rsp_keep (rsp_keep)
    );
endmodule

// File: rtl/stream_prefetch_sva.sv
module stream_prefetch_sva #(
    parameter int ADDR_W = 26,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic              pf_req_valid,
    input logic              pf_req_ready,
    input logic [ADDR_W-1:0] pf_req_addr,
    input logic              pf_rsp_valid
);
    localparam int OW = $clog2(DEPTH + 2) + 1;
    logic [OW-1:0] owed;
    logic          fire;

    assign fire = pf_req_valid && pf_req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            owed <= '0;
        else if (fire && !(pf_rsp_valid && owed != '0))
            owed <= owed + OW'(1);
        else if (!fire && pf_rsp_valid && owed != '0)
            owed <= owed - OW'(1);
    end

    AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(DEPTH)); // R12

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pf_req_valid); // R10

    AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit); // R10

    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !flush) |=> (pf_req_addr == $past(lk_addr) + ADDR_W'(1))); // R8

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !flush && !(lk_valid && !lk_hit)) |=> (pf_req_addr == $past(pf_req_addr) + ADDR_W'(1))); // R3

    AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !flush) |=> !(lk_hit && lk_addr == $past(lk_addr))); // R6
endmodule

bind stream_prefetch stream_prefetch_sva #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .lk_valid     (lk_valid),
    .lk_addr      (lk_addr),
    .lk_hit       (lk_hit),
    .pf_req_valid (pf_req_valid),
    .pf_req_ready (pf_req_ready),
    .pf_req_addr  (pf_req_addr),
    .pf_rsp_valid (pf_rsp_valid)
);

// File: tb/stream_prefetch_test.sv
module stream_prefetch_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int BW = 32;
    localparam int DEPTH = 4;
    localparam int NV = 11;
    // {address, expected hit, idle cycles before}
    localparam logic [24:0] VEC [NV] = '{
        {16'h0100, 1'b0, 8'd0},
        {16'h0101, 1'b1, 8'd10},
        {16'h0102, 1'b1, 8'd0},
        {16'h0104, 1'b0, 8'd0},
        {16'h0105, 1'b1, 8'd10},
        {16'h0106, 1'b1, 8'd0},
        {16'h0107, 1'b1, 8'd0},
        {16'h0108, 1'b1, 8'd0},
        {16'h0109, 1'b1, 8'd10},
        {16'h0200, 1'b0, 8'd0},
        {16'h0201, 1'b1, 8'd10}
    };

    logic clk = 0, rst_n = 0, flush = 0, lk_valid = 0, lk_hit;
    logic [AW-1:0] lk_addr = '0, pf_req_addr;
    logic [BW-1:0] lk_data, pf_rsp_data = '0;
    logic pf_req_valid, pf_req_ready = 1'b1, pf_rsp_valid = 0;
    bit   rsp_en = 1, done = 0;
    int   checks = 0, errors = 0, cyc = 0, wr = 0, rd = 0;
    logic [AW-1:0] qa [256];
    int   qt [256];

    stream_prefetch #(.ADDR_W(AW), .BLK_W(BW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
        .pf_req_addr(pf_req_addr), .pf_rsp_valid(pf_rsp_valid),
        .pf_rsp_data(pf_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [BW-1:0] blk(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    // Next-level model: in-order responses two cycles after the request
    initial forever begin
        @(negedge clk);
        cyc++;
        pf_rsp_valid = 0;
        if (!rst_n) begin
            wr = 0;
            rd = 0;
        end else begin
            if (rsp_en && rd < wr && cyc - qt[rd] >= 2) begin
                pf_rsp_valid = 1;
                pf_rsp_data  = blk(qa[rd]);
                rd++;
            end
            if (pf_req_valid && pf_req_ready && wr < 256) begin
                qa[wr] = pf_req_addr;
                qt[wr] = cyc;
                wr++;
            end
        end
    end

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic lookup(input logic [AW-1:0] a, input bit eh, input string rq);
        @(negedge clk);
        lk_valid = 1;
        lk_addr  = a;
        #1;
        check(rq, 64'(lk_hit), 64'(eh));
        if (eh) check(rq, 64'(lk_data), 64'(blk(a)));
        @(posedge clk);
        #1 lk_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; lk_valid = 0; flush = 0; rsp_en = 1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0;
        do_reset();
        @(negedge clk); #1;
        check("R1 no request", 64'(pf_req_valid), 64'(0));
        check("R1 no hit", 64'(lk_hit), 64'(0));

        // Table walk: hits, pops, head-only compare, restarts, order of fill
        for (int i = 0; i < NV; i++) begin
            idle(int'(VEC[i][7:0]));
            lookup(VEC[i][24:9], VEC[i][8], "R5 R9 R13 table");
        end

        // R2 R3 R4 R6: stream start, step, cap and refill after pop
        do_reset();
        lookup(16'h0500, 1'b0, "R8 start miss");
        idle(15);
        check("R4 request count", 64'(wr), 64'(DEPTH));
        for (int i = 0; i < DEPTH; i++)
            check("R2 R3 request address", 64'(qa[i]), 64'(16'h0501 + i));
        lookup(16'h0501, 1'b1, "R5 head hit");
        idle(10);
        check("R6 refill count", 64'(wr), 64'(DEPTH + 1));
        check("R6 refill address", 64'(qa[DEPTH]), 64'(16'h0505));

        // R10 flush
        @(negedge clk); flush = 1;
        @(posedge clk); #1 flush = 0;
        @(negedge clk); #1;
        check("R10 no request after flush", 64'(pf_req_valid), 64'(0));
        w0 = wr;
        idle(10);
        check("R10 stream stopped", 64'(wr), 64'(w0));
        lookup(16'h0502, 1'b0, "R10 flushed entry misses");

        // R7 pending head does not match
        do_reset();
        rsp_en = 0;
        lookup(16'h0400, 1'b0, "R8 start miss");
        idle(3);
        lookup(16'h0401, 1'b0, "R7 pending head");
        rsp_en = 1;
        idle(25);
        lookup(16'h0402, 1'b1, "R7 R11 restarted stream");

        // R11 R12 discard of stale responses and in-flight cap
        do_reset();
        rsp_en = 0;
        lookup(16'h0300, 1'b0, "R8 start miss");
        idle(8);
        check("R12 in flight", 64'(wr - rd), 64'(DEPTH));
        lookup(16'h0310, 1'b0, "R8 restart miss");
        w0 = wr;
        idle(4);
        check("R12 capped", 64'(wr - rd), 64'(DEPTH));
        check("R12 request held", 64'(pf_req_valid), 64'(0));
        rsp_en = 1;
        idle(20);
        check("R8 restart address", 64'(qa[w0]), 64'(16'h0311));
        lookup(16'h0311, 1'b1, "R11 stale data dropped");
        lookup(16'h0312, 1'b1, "R11 R13 second entry");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule